// File: doc/BRIEF.md
# I2C Byte-Handshake Master Engine

This block drives an I2C bus as the only master. It moves one byte at a time and stops between bytes until the controlling logic pulses `go`. The first byte of a message is the address byte, made of a 7-bit target address and a direction bit. Each later byte is either sent from `tx_byte` (write) or received into `rx_byte` (read). After every byte, including the address byte, the engine holds SCL low, raises `ev_byte_done`, and waits.

The three control inputs sampled with `go` decide what happens next:
- `end_xfer` sends STOP and frees the bus.
- `new_msg` begins the next message with a repeated START, without freeing the bus.
- `nack_next` sets whether the master answers the next read byte with ACK or NACK.

With none of them set, `go` moves the next data byte.

Both bus lines are open drain. A high output-enable pulls the line low, and the line levels are read back through separate inputs. Half-periods of SCL come from a prescaler whose divisor is picked by the speed select latched at each START. While SCL is released, a watchdog counts prescaler ticks. If the line stays low for too long, the transfer is aborted.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the engine is idle: `bus_ready`=1, `scl_oe`=0, `sda_oe`=0, and all event outputs are 0.
- R2: A `go` pulse while `bus_ready`=1 sends START, then the address byte, MSB first. The address byte is `{cmd_addr[6:0], cmd_read}`, where `cmd_read`=1 means read. `bus_ready` is 0 from the next cycle on.
- R3: After each byte's ninth (acknowledge) clock, the engine pulses `ev_byte_done` for one cycle. It then holds SCL low (`scl_oe`=1) until the next `go`. A `go` that arrives while a byte is still moving has no effect.
- R4: A write data byte is taken from `tx_byte` when `go` is sampled. `rx_nack` then shows the acknowledge bit read back: 0 means ACK, 1 means NACK. A NACK on a data byte raises no `ev_addr_nack`.
- R5: When the target does not acknowledge the address byte, `ev_addr_nack` pulses in the same cycle as `ev_byte_done`, and `rx_nack` becomes 1.
- R6: A read byte is presented on `rx_byte` in the cycle `ev_byte_done` pulses. The master answers it with NACK if `nack_next` was 1 at the `go` that started the byte, and with ACK otherwise.
- R7: `go` with `end_xfer`=1 while waiting sends STOP and returns to idle with both lines released. `end_xfer` takes priority over `new_msg`.
- R8: `go` with `new_msg`=1 and `end_xfer`=0 while waiting sends a repeated START, then a new address byte built from the current `cmd_addr` and `cmd_read`. No STOP is sent in between.
- R9: After the address byte, a message of zero data bytes ends with `go` plus `end_xfer`. The bus then carries exactly one START, one address byte and one STOP.
- R10: Each SCL half-period lasts `STD_DIV` clock cycles when `cmd_fast`=0 at the START, and `FAST_DIV` cycles when it was 1. Stretching by the target lengthens the high half.
- R11: SDA changes only while SCL is held low. The only exceptions are the START and STOP edges and an abort.
- R12: While SCL is released, if the line reads low for `scl_limit` prescaler ticks in a row, the engine does three things in one cycle: it pulses `ev_scl_timeout`, releases both lines, and becomes idle. A `scl_limit` of 0 turns the check off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_addr | input | 7 | Target address for the next address byte |
| cmd_read | input | 1 | 1 = read message, 0 = write message |
| cmd_fast | input | 1 | 1 = fast divisor, 0 = standard divisor (latched at START) |
| tx_byte | input | 8 | Byte to send on a write data byte |
| go | input | 1 | One-cycle proceed handshake |
| nack_next | input | 1 | Answer the next read byte with NACK |
| end_xfer | input | 1 | With `go`: send STOP |
| new_msg | input | 1 | With `go`: send repeated START and a new address byte |
| scl_limit | input | LIMIT_W | SCL-stuck limit in prescaler ticks, 0 = off |
| rx_byte | output | 8 | Last received read byte |
| rx_nack | output | 1 | Last acknowledge bit read back from the target |
| bus_ready | output | 1 | Engine idle and bus released |
| ev_addr_nack | output | 1 | One-cycle pulse: address byte not acknowledged |
| ev_byte_done | output | 1 | One-cycle pulse: byte finished, engine waiting |
| ev_scl_timeout | output | 1 | One-cycle pulse: SCL stuck low, transfer aborted |
| scl_oe | output | 1 | Pull SCL low |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
An address byte that no target acknowledges ends in one cycle with two reports: `ev_byte_done` and `ev_addr_nack`. The bench provokes this by addressing a number its modelled target does not answer. It then judges, at the very sample where the byte-end event is seen, that the NACK event is also high and `rx_nack` is 1. The opposite case gets the same check: a data byte the target refuses must raise `ev_byte_done` without `ev_addr_nack`. A second coincidence is a `go` that lands while a byte is still moving. The bench pulses one mid-byte and confirms by counting events and the bytes the target received that the pulse did nothing.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RS_LO,
        ST_RS_HI,
        ST_RS_SDA,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_WAIT,
        ST_SP_LO,
        ST_SP_HI,
        ST_SP_REL
    } bm_state_e;

endpackage

// File: rtl/i2c_half_timer.sv
// Half-period tick source: restarts on request and counts DIV cycles per tick.
module i2c_half_timer #(
    parameter int STD_DIV  = 10,
    parameter int FAST_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic fast,
    output logic tick
);
    localparam int MAX_DIV = (STD_DIV > FAST_DIV) ? STD_DIV : FAST_DIV;
    localparam int CW      = $clog2(MAX_DIV + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] full_v, first_v;

    always_comb begin
        full_v  = fast ? CW'(FAST_DIV - 1) : CW'(STD_DIV - 1);
        first_v = fast ? CW'(FAST_DIV - 2) : CW'(STD_DIV - 2);
        tick    = (cnt_q == '0) && !restart;
        if (restart)        cnt_d = first_v;
        else if (tick)      cnt_d = full_v;
        else                cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_scl_watch.sv
// Counts prescaler ticks while a released SCL still reads low.
module i2c_scl_watch #(
    parameter int LIMIT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               watch,
    input  logic               tick,
    input  logic               scl_in,
    input  logic [LIMIT_W-1:0] limit,
    output logic               expired
);
    logic [LIMIT_W-1:0] cnt_d, cnt_q;
    logic [LIMIT_W:0]   next_v;

    always_comb begin
        next_v  = {1'b0, cnt_q} + 1'b1;
        expired = watch && !scl_in && tick && (limit != '0) && (next_v == {1'b0, limit});
        if (!watch || scl_in) cnt_d = '0;
        else if (tick)        cnt_d = (cnt_q == '1) ? cnt_q : next_v[LIMIT_W-1:0];
        else                  cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int STD_DIV  = 10,
    parameter int FAST_DIV = 4,
    parameter int LIMIT_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [6:0]         cmd_addr,
    input  logic               cmd_read,
    input  logic               cmd_fast,
    input  logic [7:0]         tx_byte,
    input  logic               go,
    input  logic               nack_next,
    input  logic               end_xfer,
    input  logic               new_msg,
    input  logic [LIMIT_W-1:0] scl_limit,
    output logic [7:0]         rx_byte,
    output logic               rx_nack,
    output logic               bus_ready,
    output logic               ev_addr_nack,
    output logic               ev_byte_done,
    output logic               ev_scl_timeout,
    output logic               scl_oe,
    input  logic               scl_in,
    output logic               sda_oe,
    input  logic               sda_in
);
    localparam int SH_W = BYTE_W + 1;

    typedef struct packed {
        bm_state_e              st;
        logic [SH_W-1:0]        sh;
        logic [BIT_CNT_W-1:0]   bitn;
        logic                   rd;
        logic                   addr_ph;
        logic                   fast;
        logic                   sda_oe;
        logic                   tmr_rst;
        logic [BYTE_W-1:0]      rx;
        logic                   rx_nack;
        logic                   ev_done;
        logic                   ev_anack;
        logic                   ev_to;
    } bm_regs_t;

    bm_regs_t  d, q;
    logic      tick, expired, watch, adv;
    bm_state_e st_mon;

    i2c_half_timer #(.STD_DIV(STD_DIV), .FAST_DIV(FAST_DIV)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(q.tmr_rst), .fast(q.fast), .tick(tick)
    );

    i2c_scl_watch #(.LIMIT_W(LIMIT_W)) u_watch (
        .clk(clk), .rst_n(rst_n), .watch(watch), .tick(tick),
        .scl_in(scl_in), .limit(scl_limit), .expired(expired)
    );

    always_comb begin
        watch = (q.st == ST_RS_HI) || (q.st == ST_BIT_HI) || (q.st == ST_SP_HI);
        adv   = tick && scl_in;
        d          = q;
        d.ev_done  = 1'b0;
        d.ev_anack = 1'b0;
        d.ev_to    = 1'b0;
        unique case (q.st)
            ST_IDLE: if (go) begin
                d.sh      = {cmd_addr, cmd_read, 1'b1};
                d.rd      = cmd_read;
                d.fast    = cmd_fast;
                d.addr_ph = 1'b1;
                d.bitn    = '0;
                d.st      = ST_RS_HI;
            end
            ST_RS_LO: begin
                d.sda_oe = 1'b0;
                if (tick) d.st = ST_RS_HI;
            end
            ST_RS_HI:  if (adv) d.st = ST_RS_SDA;
            ST_RS_SDA: begin
                d.sda_oe = 1'b1;
                if (tick) d.st = ST_BIT_LO;
            end
            ST_BIT_LO: begin
                d.sda_oe = ~q.sh[SH_W-1];
                if (tick) d.st = ST_BIT_HI;
            end
            ST_BIT_HI: if (adv) begin
                d.sh = {q.sh[SH_W-2:0], sda_in};
                if (q.bitn == BIT_CNT_W'(BYTE_W)) begin
                    d.st      = ST_WAIT;
                    d.ev_done = 1'b1;
                    if (q.addr_ph) begin
                        d.ev_anack = sda_in;
                        d.rx_nack  = sda_in;
                    end else if (q.rd) begin
                        d.rx = q.sh[BYTE_W-1:0];
                    end else begin
                        d.rx_nack = sda_in;
                    end
                end else begin
                    d.bitn = q.bitn + 1'b1;
                    d.st   = ST_BIT_LO;
                end
            end
            ST_WAIT: if (go) begin
                d.bitn = '0;
                if (end_xfer) begin
                    d.st = ST_SP_LO;
                end else if (new_msg) begin
                    d.sh      = {cmd_addr, cmd_read, 1'b1};
                    d.rd      = cmd_read;
                    d.fast    = cmd_fast;
                    d.addr_ph = 1'b1;
                    d.st      = ST_RS_LO;
                end else begin
                    d.sh      = q.rd ? {{BYTE_W{1'b1}}, nack_next} : {tx_byte, 1'b1};
                    d.addr_ph = 1'b0;
                    d.st      = ST_BIT_LO;
                end
            end
            ST_SP_LO: begin
                d.sda_oe = 1'b1;
                if (tick) d.st = ST_SP_HI;
            end
            ST_SP_HI:  if (adv) d.st = ST_SP_REL;
            ST_SP_REL: begin
                d.sda_oe = 1'b0;
                if (tick) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
        if (expired) begin
            d.st     = ST_IDLE;
            d.sda_oe = 1'b0;
            d.ev_to  = 1'b1;
        end
        d.tmr_rst = (d.st != q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign scl_oe         = (q.st == ST_RS_LO) || (q.st == ST_BIT_LO) ||
                            (q.st == ST_WAIT)  || (q.st == ST_SP_LO);
    assign sda_oe         = q.sda_oe;
    assign bus_ready      = (q.st == ST_IDLE);
    assign rx_byte        = q.rx;
    assign rx_nack        = q.rx_nack;
    assign ev_byte_done   = q.ev_done;
    assign ev_addr_nack   = q.ev_anack;
    assign ev_scl_timeout = q.ev_to;
    assign st_mon         = q.st;
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk
    import i2c_bm_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_oe,
    input logic      sda_oe,
    input logic      bus_ready,
    input logic      ev_byte_done,
    input logic      ev_addr_nack,
    input logic      ev_scl_timeout,
    input bm_state_e st
);
    // R5: an address NACK is reported together with the byte end
    assert_anack_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_addr_nack |-> ev_byte_done);

    // R3: once a byte is done, SCL is held low
    assert_hold_scl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_byte_done |-> scl_oe);

    // R7: an idle engine drives neither line
    assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> (!scl_oe && !sda_oe));

    // R11: SDA moves under a released SCL only for START, STOP or an abort
    assert_sda_under_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(scl_oe)) |->
            ($past(st) == ST_RS_SDA || $past(st) == ST_SP_REL || ev_scl_timeout));

    // R12: a timeout leaves the bus released and never coincides with a byte end
    assert_abort_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_scl_timeout |-> (bus_ready && !scl_oe && !sda_oe && !ev_byte_done));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .bus_ready(bus_ready), .ev_byte_done(ev_byte_done),
    .ev_addr_nack(ev_addr_nack), .ev_scl_timeout(ev_scl_timeout), .st(st_mon)
);

// File: tb/sim_i2c_byte_master.sv
`timescale 1ns/1ps
module sim_i2c_byte_master;
    localparam int STD_DIV  = 10;
    localparam int FAST_DIV = 4;
    localparam logic [6:0] TADDR = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] cmd_addr = '0;
    logic cmd_read = 1'b0, cmd_fast = 1'b0;
    logic [7:0] tx_byte = '0;
    logic go = 1'b0, nack_next = 1'b0, end_xfer = 1'b0, new_msg = 1'b0;
    logic [7:0] scl_limit = 8'd200;
    logic [7:0] rx_byte;
    logic rx_nack, bus_ready, ev_addr_nack, ev_byte_done, ev_scl_timeout;
    logic scl_oe, sda_oe;
    logic hold_scl = 1'b0;
    logic t_drv = 1'b0;
    wire  scl_line = !(scl_oe | hold_scl);
    wire  sda_line = !(sda_oe | t_drv);

    always #4 clk = ~clk;

    i2c_byte_master #(.STD_DIV(STD_DIV), .FAST_DIV(FAST_DIV), .LIMIT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .cmd_read(cmd_read),
        .cmd_fast(cmd_fast), .tx_byte(tx_byte), .go(go), .nack_next(nack_next),
        .end_xfer(end_xfer), .new_msg(new_msg), .scl_limit(scl_limit),
        .rx_byte(rx_byte), .rx_nack(rx_nack), .bus_ready(bus_ready),
        .ev_addr_nack(ev_addr_nack), .ev_byte_done(ev_byte_done),
        .ev_scl_timeout(ev_scl_timeout), .scl_oe(scl_oe), .scl_in(scl_line),
        .sda_oe(sda_oe), .sda_in(sda_line)
    );

    // behavioural target
    int   t_starts = 0, t_stops = 0, t_bit = 0;
    bit   t_act = 0, t_addr = 0, t_rd = 0, t_match = 0;
    bit   force_data_nack = 0;
    logic [7:0] t_sh = '0, t_tx = '0;
    logic [7:0] t_rxq[$];
    logic [7:0] t_txq[$];
    bit         t_mack[$];

    always @(negedge sda_line) if (scl_line === 1'b1) begin
        t_starts++; t_bit = 0; t_addr = 1; t_act = 1; t_drv = 0;
    end
    always @(posedge sda_line) if (scl_line === 1'b1) begin
        t_stops++; t_act = 0; t_drv = 0;
    end
    always @(posedge scl_line) if (t_act) begin
        if (t_bit < 8) t_sh = {t_sh[6:0], sda_line};
        else if (t_rd && !t_addr) t_mack.push_back(sda_line);
        t_bit++;
    end
    always @(negedge scl_line) if (t_act) begin
        if (t_bit == 8) begin
            if (t_addr) begin
                t_rd = t_sh[0]; t_match = (t_sh[7:1] == TADDR); t_drv = t_match;
            end else if (t_rd) t_drv = 0;
            else begin t_rxq.push_back(t_sh); t_drv = !force_data_nack; end
        end else if (t_bit == 9) begin
            t_bit = 0;
            if (t_addr) begin
                t_addr = 0;
                if (!t_match) begin t_act = 0; t_drv = 0; end
                else if (t_rd) begin
                    t_tx = (t_txq.size() > 0) ? t_txq.pop_front() : 8'hFF; t_drv = ~t_tx[7];
                end else t_drv = 0;
            end else if (t_rd) begin
                if (t_mack[$] == 1'b0) begin
                    t_tx = (t_txq.size() > 0) ? t_txq.pop_front() : 8'hFF; t_drv = ~t_tx[7];
                end else begin t_drv = 0; t_act = 0; end
            end else t_drv = 0;
        end else if (t_rd && !t_addr && t_bit > 0) t_drv = ~t_tx[7 - t_bit];
    end

    // monitors
    int cyc = 0, last_rise = 0, per = 0, n_done = 0, n_to = 0;
    always @(posedge clk) cyc++;
    always @(posedge scl_line) begin per = cyc - last_rise; last_rise = cyc; end
    always @(negedge clk) begin
        if (ev_byte_done) n_done++;
        if (ev_scl_timeout) n_to++;
    end

    int n_chk = 0, n_bad = 0;
    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    task automatic go_pulse(input bit e, input bit n, input bit nk);
        @(negedge clk);
        end_xfer = e; new_msg = n; nack_next = nk; go = 1'b1;
        @(negedge clk);
        go = 1'b0; end_xfer = 1'b0; new_msg = 1'b0; nack_next = 1'b0;
    endtask

    task automatic wait_done(output bit ok, output bit an, output bit nk);
        ok = 0; an = 0; nk = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (ev_byte_done) begin ok = 1; an = ev_addr_nack; nk = rx_nack; break; end
        end
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (bus_ready) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        bit ok, an, nk;
        int s0, p0, d0;
        repeat (4) @(negedge clk);
        chk("R1", "bus_ready", bus_ready, 1);
        chk("R1", "scl_oe", scl_oe, 0);
        chk("R1", "sda_oe", sda_oe, 0);
        chk("R1", "events", {ev_addr_nack, ev_byte_done, ev_scl_timeout}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // write of two bytes, stray go mid-byte
        cmd_addr = TADDR; cmd_read = 0; cmd_fast = 0;
        s0 = t_starts; p0 = t_stops; d0 = n_done;
        go_pulse(0, 0, 0);
        chk("R2", "bus_ready after go", bus_ready, 0);
        wait_done(ok, an, nk);
        chk("R2", "address byte done", ok, 1);
        chk("R2", "address acked", {an, nk}, 0);
        chk("R10", "standard SCL period", per, 2 * STD_DIV);
        repeat (40) @(negedge clk);
        chk("R3", "SCL held low while waiting", {scl_oe, bus_ready}, 2'b10);
        tx_byte = 8'hA5;
        go_pulse(0, 0, 0);
        repeat (30) @(negedge clk);
        tx_byte = 8'hFF;
        go_pulse(0, 0, 0);
        wait_done(ok, an, nk);
        chk("R4", "data byte acked", {ok, an, nk}, 3'b100);
        tx_byte = 8'h3C;
        go_pulse(0, 0, 0);
        wait_done(ok, an, nk);
        go_pulse(1, 0, 0);
        wait_ready();
        chk("R3", "byte_done count", n_done - d0, 3);
        chk("R4", "target byte count", t_rxq.size(), 2);
        chk("R4", "target bytes", {t_rxq[0], t_rxq[1]}, 16'hA53C);
        chk("R7", "stop count", t_stops - p0, 1);
        chk("R11", "start count", t_starts - s0, 1);
        chk("R7", "released after stop", {bus_ready, scl_oe, sda_oe}, 3'b100);

        // read of two bytes
        t_txq.push_back(8'hC3); t_txq.push_back(8'h7E); t_mack.delete();
        cmd_read = 1;
        go_pulse(0, 0, 0);
        wait_done(ok, an, nk);
        chk("R2", "read address acked", {ok, an}, 2'b10);
        go_pulse(0, 0, 0);
        wait_done(ok, an, nk);
        chk("R6", "first read byte", rx_byte, 8'hC3);
        go_pulse(0, 0, 1);
        wait_done(ok, an, nk);
        chk("R6", "second read byte", rx_byte, 8'h7E);
        chk("R6", "master ack bits", {t_mack.size() == 2, t_mack[0], t_mack[1]}, 3'b101);
        go_pulse(1, 0, 0);
        wait_ready();

        // address not acknowledged
        cmd_addr = 7'h11; cmd_read = 0;
        go_pulse(0, 0, 0);
        wait_done(ok, an, nk);
        chk("R5", "address NACK with byte end", {ok, an, nk}, 3'b111);
        go_pulse(1, 0, 0);
        wait_ready();
        chk("R5", "idle after NACKed message", bus_ready, 1);

        // data byte not acknowledged
        cmd_addr = TADDR;
        go_pulse(0, 0, 0);
        wait_done(ok, an, nk);
        force_data_nack = 1; tx_byte = 8'h5E;
        go_pulse(0, 0, 0);
        wait_done(ok, an, nk);
        chk("R4", "data NACK without address NACK", {ok, an, nk}, 3'b101);
        force_data_nack = 0;
        go_pulse(1, 0, 0);
        wait_ready();

        // zero-length write, fast, end beats new_msg
        t_rxq.delete(); cmd_fast = 1; s0 = t_starts; p0 = t_stops;
        go_pulse(0, 0, 0);
        wait_done(ok, an, nk);
        chk("R10", "fast SCL period", per, 2 * FAST_DIV);
        go_pulse(1, 1, 0);
        wait_ready();
        chk("R9", "no data bytes", t_rxq.size(), 0);
        chk("R9", "one start one stop", {t_starts - s0, t_stops - p0}, {32'd1, 32'd1});
        chk("R7", "end priority over new_msg", bus_ready, 1);

        // repeated START between write and read
        cmd_fast = 0; cmd_read = 0; s0 = t_starts; p0 = t_stops;
        go_pulse(0, 0, 0);
        wait_done(ok, an, nk);
        tx_byte = 8'h11;
        go_pulse(0, 0, 0);
        wait_done(ok, an, nk);
        cmd_read = 1; t_txq.delete(); t_txq.push_back(8'h96);
        go_pulse(0, 1, 0);
        wait_done(ok, an, nk);
        chk("R8", "restart address acked", {ok, an}, 2'b10);
        chk("R8", "two starts no stop", {t_starts - s0, t_stops - p0}, {32'd2, 32'd0});
        go_pulse(0, 0, 1);
        wait_done(ok, an, nk);
        chk("R8", "read after restart", rx_byte, 8'h96);
        go_pulse(1, 0, 0);
        wait_ready();
        chk("R8", "write before restart", t_rxq[$], 8'h11);

        // SCL stuck low: abort
        cmd_read = 0; scl_limit = 8'd3; hold_scl = 1; d0 = n_to;
        go_pulse(0, 0, 0);
        for (int i = 0; i < 500; i++) begin
            if (ev_scl_timeout) break;
            @(negedge clk);
        end
        chk("R12", "timeout event", ev_scl_timeout, 1);
        chk("R12", "released on abort", {bus_ready, scl_oe, sda_oe}, 3'b100);
        hold_scl = 0;
        repeat (5) @(negedge clk);

        // limit zero: no abort, stretch then continue
        scl_limit = 8'd0; hold_scl = 1;
        go_pulse(0, 0, 0);
        repeat (400) @(negedge clk);
        chk("R12", "no abort with limit 0", {n_to - d0, bus_ready}, {32'd1, 1'b0});
        hold_scl = 0;
        wait_done(ok, an, nk);
        chk("R10", "byte finishes after stretch", {ok, an}, 2'b10);
        go_pulse(1, 0, 0);
        wait_ready();

        summary();
        $finish;
    end
endmodule